// File: doc/BRIEF.md
# Modulo 2^16+1 Multiplier

This block multiplies two W-bit operands (W = 16 by default) and reduces the product modulo 2^W+1. Cipher rounds that mix operations over different algebraic groups use this kind of multiply. The full double-width product is formed in the cycle that accepts the operands. A restoring reduction then runs one step per clock. It keeps a copy of the modulus shifted left by W-1 (0x80008000 for W = 16). On each step the copy is subtracted from the working value if it fits, and then the copy moves one bit to the right. After W steps the working value is the residue.

Operands arrive on a valid/ready input channel and the result leaves on a valid/ready output channel. The block holds one job at a time. `in_ready` is high only when no job is running and no result is waiting. A finished result stays on `out_prod` with `out_valid` high until the consumer raises `out_ready`, so the consumer may stall for as long as it needs. The residue 2^W does not fit in W bits and is delivered as 0. With the parameter `ZERO_IS_2W` set, an operand of 0 is read as 2^W. That makes the block a multiply in which 0 stands for 2^W on both the inputs and the output.

Top module: `mod_mul_2n1`

## Requirements
- R1: After reset, and before any operands are accepted, `in_ready` is 1 and `out_valid` is 0.
- R2: An operand pair is taken on a rising edge where `in_valid` and `in_ready` are both 1. From that edge until the result is released, `in_ready` stays 0.
- R3: `out_valid` first reads 1 after the W-th rising edge that follows the accepting edge (the 16th edge for W = 16).
- R4: With `ZERO_IS_2W` = 0, `out_prod` equals (op_a * op_b) mod (2^W+1), and a residue of 2^W is delivered as 0.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_prod` does not change.
- R6: After a rising edge where `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1. A pair offered in that same cycle is not taken on that edge. It is taken on the next edge.
- R7: Values on `op_a`, `op_b` and `in_valid` while a job is running do not affect the result of that job, and they do not start a second job.
- R8: With `ZERO_IS_2W` = 1, an operand of 0 counts as 2^W, and a residue of 2^W is delivered as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take an operand pair |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| out_valid | output | 1 | Residue is present on `out_prod` |
| out_ready | input | 1 | Consumer takes the residue |
| out_prod | output | W | Product modulo 2^W+1 |

## Verification
Two things can happen in the same cycle: the consumer releasing a finished result, and the producer offering the next operand pair. The bench offers the next pair in the very cycle it raises `out_ready`, on every transaction. It checks that `in_ready` is still low in that cycle, that `out_valid` falls after the edge, and that the pair is taken one edge later with a correct residue. It also puts unrelated operands and stray `in_valid` pulses on the inputs while a job runs, and it holds results under back-pressure for zero to two cycles. The bench sweeps every operand pair at W = 4 in both zero modes. At W = 16 it runs all pairs of the edge values 0, 1, 2, 0x8000, 0x8001 and 0xFFFF, which includes pairs whose residue is 2^16, plus random pairs.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    MM_IDLE = 2'd0,
    MM_RUN  = 2'd1,
    MM_HOLD = 2'd2
  } mm_state_e;

endpackage

// File: rtl/mm_opmap.sv
module mm_opmap #(
  parameter int W          = 16,
  parameter bit ZERO_IS_2W = 1'b0
) (
  input  logic [W-1:0] raw,
  output logic [W:0]   eff
);

  generate
    if (ZERO_IS_2W) begin : g_zero_max
      always_comb begin
        if (raw == '0) eff = {1'b1, {W{1'b0}}};
        else           eff = {1'b0, raw};
      end
    end else begin : g_plain
      assign eff = {1'b0, raw};
    end
  endgenerate

endmodule

// File: rtl/mm_step.sv
module mm_step #(
  parameter int PW = 34
) (
  input  logic [PW-1:0] rem_i,
  input  logic [PW-1:0] div_i,
  output logic [PW-1:0] rem_o
);

  logic fits;

  assign fits  = (rem_i >= div_i);
  assign rem_o = fits ? (rem_i - div_i) : rem_i;

endmodule

// File: rtl/mm_seq.sv
module mm_seq
  import mm_pkg::*;
#(
  parameter int ITER = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load,
  output logic step
);

  localparam int CW = $clog2(ITER + 1);
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  mm_state_e   st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MM_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        MM_IDLE: begin
          if (in_valid) begin
            st_q  <= MM_RUN;
            cnt_q <= '0;
          end
        end
        MM_RUN: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == LAST) st_q <= MM_HOLD;
        end
        MM_HOLD: begin
          if (out_ready) st_q <= MM_IDLE;
        end
        default: st_q <= MM_IDLE;
      endcase
    end
  end

  assign in_ready  = (st_q == MM_IDLE);
  assign out_valid = (st_q == MM_HOLD);
  assign load      = in_ready & in_valid;
  assign step      = (st_q == MM_RUN);

endmodule

// File: rtl/mod_mul_2n1.sv
module mod_mul_2n1 #(
  parameter int W          = 16,
  parameter bit ZERO_IS_2W = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_prod
);

  localparam int PW = 2 * W + 2;
  localparam logic [PW-1:0] MODV = (PW'(1) << W) | PW'(1);
  localparam logic [PW-1:0] DIV0 = MODV << (W - 1);

  logic [W:0]    eff_a, eff_b;
  logic [PW-1:0] prod_full;
  logic [PW-1:0] rem_q, div_q, rem_nx;
  logic          load, step;

  mm_opmap #(.W(W), .ZERO_IS_2W(ZERO_IS_2W)) u_map_a (.raw(op_a), .eff(eff_a));
  mm_opmap #(.W(W), .ZERO_IS_2W(ZERO_IS_2W)) u_map_b (.raw(op_b), .eff(eff_b));

  assign prod_full = {{(W+1){1'b0}}, eff_a} * {{(W+1){1'b0}}, eff_b};

  mm_step #(.PW(PW)) u_step (.rem_i(rem_q), .div_i(div_q), .rem_o(rem_nx));

  mm_seq #(.ITER(W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .step      (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      div_q <= '0;
    end else if (load) begin
      rem_q <= prod_full;
      div_q <= DIV0;
    end else if (step) begin
      rem_q <= rem_nx;
      div_q <= div_q >> 1;
    end
  end

  assign out_prod = rem_q[W-1:0];

endmodule

// File: rtl/mm_chk.sv
module mm_chk #(
  parameter int W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [W-1:0]    out_prod,
  input logic [2*W+1:0]  rem_q
);

  localparam int PW = 2 * W + 2;
  localparam logic [PW-1:0] TOPV = PW'(1) << W;

  int since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_q <= 0;
    else if (in_valid && in_ready)       since_q <= 1;
    else if (since_q != 0 && since_q < 1000000) since_q <= since_q + 1;
  end

  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !out_valid)); // R2

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (since_q == W + 1)); // R3

  AST_RESIDUE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rem_q <= TOPV)); // R4

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_prod)); // R5

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready)); // R6

endmodule

bind mod_mul_2n1 mm_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_prod  (out_prod),
  .rem_q     (rem_q)
);

// File: tb/mod_mul_2n1_tb.sv
module mod_mul_2n1_tb_lane #(
  parameter int W       = 16,
  parameter bit ZERO    = 1'b0,
  parameter bit EXHAUST = 1'b0,
  parameter int NRAND   = 200,
  parameter int LANE    = 0
) (
  input  logic clk,
  input  logic rst_n,
  output logic finished,
  output int   n_run,
  output int   n_fail
);

  localparam int NEDGE = 6;
  localparam int NCASE = EXHAUST ? (1 << (2 * W)) : (NEDGE * NEDGE + NRAND);

  logic         in_valid, in_ready, out_valid, out_ready;
  logic [W-1:0] op_a, op_b, out_prod;
  logic [W-1:0] va [NCASE];
  logic [W-1:0] vb [NCASE];

  mod_mul_2n1 #(.W(W), .ZERO_IS_2W(ZERO)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod)
  );

  function automatic longint expect_of(longint a, longint b);
    longint top = longint'(1) << W;
    longint r;
    if (ZERO && a == 0) a = top;
    if (ZERO && b == 0) b = top;
    r = (a * b) % (top + 1);
    if (r == top) r = 0;
    return r;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s lane %0d: got %0d expected %0d", req, LANE, act, exp);
    end
  endtask

  function automatic logic [W-1:0] edge_val(int k);
    case (k)
      0: return '0;
      1: return W'(1);
      2: return '1;
      3: return W'(1) << (W - 1);
      4: return (W'(1) << (W - 1)) | W'(1);
      default: return W'(2);
    endcase
  endfunction

  initial begin
    finished = 0; n_run = 0; n_fail = 0;
    in_valid = 0; out_ready = 0; op_a = '0; op_b = '0;
    for (int i = 0; i < NCASE; i++) begin
      if (EXHAUST) begin
        va[i] = W'(i >> W);
        vb[i] = W'(i);
      end else if (i < NEDGE * NEDGE) begin
        va[i] = edge_val(i / NEDGE);
        vb[i] = edge_val(i % NEDGE);
      end else begin
        va[i] = W'($urandom);
        vb[i] = W'($urandom);
      end
    end
    wait (rst_n === 1'b1);
    @(negedge clk);
    check("R1 in_ready", longint'(in_ready), 1);
    check("R1 out_valid", longint'(out_valid), 0);
    in_valid = 1; op_a = va[0]; op_b = vb[0];
    for (int i = 0; i < NCASE; i++) begin
      longint exp_r;
      int cnt;
      logic [W-1:0] held;
      exp_r = expect_of(longint'(va[i]), longint'(vb[i]));
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      check("R2 busy", longint'(in_ready), 0);
      // R7: unrelated operands and a stray valid while the job runs
      op_a = ~va[i]; op_b = va[i] ^ vb[i]; in_valid = (i % 2 == 0);
      cnt = 0;
      while (!out_valid && cnt < W + 8) begin
        @(negedge clk);
        cnt++;
        if (cnt == 2) in_valid = 0;
      end
      check("R3 latency", longint'(cnt), longint'(W));
      check(ZERO ? "R8 R7 residue" : "R4 R7 residue", longint'(out_prod), exp_r);
      held = out_prod;
      for (int h = 0; h < i % 3; h++) begin
        @(negedge clk);
        check("R5 valid held", longint'(out_valid), 1);
        check("R5 data held", longint'(out_prod), longint'(held));
      end
      out_ready = 1;
      if (i + 1 < NCASE) begin
        in_valid = 1; op_a = va[i+1]; op_b = vb[i+1];
      end
      check("R6 no same-cycle take", longint'(in_ready), 0);
      @(negedge clk);
      check("R6 released", longint'(out_valid), 0);
      check("R6 ready again", longint'(in_ready), 1);
      out_ready = 0;
    end
    in_valid = 0;
    finished = 1;
  end

endmodule

module mod_mul_2n1_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f0, f1, f2;
  int   r0, r1, r2, e0, e1, e2;

  always #2 clk = ~clk;

  mod_mul_2n1_tb_lane #(.W(16), .ZERO(1'b0), .EXHAUST(1'b0), .LANE(0))
    u_lane_wide (.clk(clk), .rst_n(rst_n), .finished(f0), .n_run(r0), .n_fail(e0));
  mod_mul_2n1_tb_lane #(.W(4), .ZERO(1'b0), .EXHAUST(1'b1), .LANE(1))
    u_lane_plain (.clk(clk), .rst_n(rst_n), .finished(f1), .n_run(r1), .n_fail(e1));
  mod_mul_2n1_tb_lane #(.W(4), .ZERO(1'b1), .EXHAUST(1'b1), .LANE(2))
    u_lane_zero (.clk(clk), .rst_n(rst_n), .finished(f2), .n_run(r2), .n_fail(e2));

  initial begin
    int cyc;
    int runs, fails;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!(f0 === 1'b1 && f1 === 1'b1 && f2 === 1'b1) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    runs  = r0 + r1 + r2;
    fails = e0 + e1 + e2;
    if (cyc >= 150000) begin
      runs++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
    end
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule